// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled by timing the two edge strobes that feed its phase-frequency detector. A fast sampling clock runs the block; the reference strobe and the feedback strobe each arrive as single-tick pulses on that clock. For every detector cycle the block counts the ticks between the first strobe and its partner. It then compares that gap with a narrow lock threshold and a wider unlock threshold.

The lock flag rises only after a programmed number of consecutive cycles have each had a gap below the lock threshold. Once the flag is up, only a gap above the unlock threshold clears it. A lost partner edge, or a repeated edge of the kind that opened the cycle, also clears it. The difference between the two thresholds gives hysteresis. A range-select input picks one of two threshold pairs, and a 2-bit field picks the run length. A disable input forces the flag low. The flag is meant to gate downstream sync generation, so that no sync can start while the loop is unlocked.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset `locked` is 0.
- R2: A cycle is good when its gap is strictly below the active lock threshold. The gap is the number of clock ticks from the tick of the opening strobe to the tick of the partner strobe. `locked` rises one clock after the partner strobe that completes the required run of consecutive good cycles, and not earlier.
- R3: While `locked` is 1, a cycle whose gap is at most the active unlock threshold keeps it at 1. A gap above the unlock threshold clears `locked` one clock after the partner strobe.
- R4: `run_sel` sets the run length: 0 means 5 cycles, 1 means 16, 2 means 64 and 3 means 255.
- R5: Before lock, any cycle that is not good sets the consecutive-run count back to zero. A full new run is then needed.
- R6: `win_sel`=0 selects lock threshold 2 and unlock threshold 4. `win_sel`=1 selects lock threshold 4 and unlock threshold 8. All thresholds are in ticks.
- R7: An open cycle whose partner has not arrived by twice the unlock threshold (8 ticks in the low range, 16 in the high range) ends as a failure. The failure clears `locked`.
- R8: Either strobe may open a cycle, and the gap is measured to the strobe of the other kind. Both strobes in the same tick give a gap of 0.
- R9: While `det_off` is 1, `locked` is 0 from the next clock on, the open measurement is dropped, and strobes are not counted. After release, a full new run is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one tick is the unit of gap measurement |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-tick strobe marking a reference edge |
| fb_edge | input | 1 | One-tick strobe marking a feedback edge |
| win_sel | input | 1 | Threshold pair select: 0 low range, 1 high range |
| run_sel | input | 2 | Consecutive-cycle count select |
| det_off | input | 1 | Detector disable; holds `locked` low |
| locked | output | 1 | Lock status |

## Verification
On every cycle, the assertions check four things. The flag rises only right after a good measurement. It falls only after disable or an over-threshold or failed measurement. It holds through any measurement within the unlock threshold, and no measured gap exceeds the timeout. They also check that the meter is silent while disabled. The exact run lengths, the reset of the run count by a marginal gap, and the precise threshold boundaries in both ranges can only be shown by the bench's scenarios. The same holds for timeout recovery and either strobe order. The bench sweeps every gap up to the timeout in both ranges, from both the unlocked and the locked state.

// File: rtl/pll_lockdet_pkg.sv
package pll_lockdet_pkg;

    localparam int unsigned LD_GAP_W = 8;
    localparam int unsigned LD_RUN_W = 8;

    typedef struct packed {
        logic                valid;
        logic                fail;
        logic [LD_GAP_W-1:0] gap;
    } meas_t;

    typedef struct packed {
        logic                open;
        logic                fb_first;
        logic [LD_GAP_W-1:0] cnt;
    } meter_st_t;

    typedef struct packed {
        logic                locked;
        logic [LD_RUN_W-1:0] run;
    } run_st_t;

endpackage

// File: rtl/lockdet_thresh.sv
module lockdet_thresh
    import pll_lockdet_pkg::*;
#(
    parameter int unsigned LO_LOCK   = 2,
    parameter int unsigned LO_UNLOCK = 4,
    parameter int unsigned HI_LOCK   = 4,
    parameter int unsigned HI_UNLOCK = 8,
    parameter int unsigned RUN_LEN0  = 5,
    parameter int unsigned RUN_LEN1  = 16,
    parameter int unsigned RUN_LEN2  = 64,
    parameter int unsigned RUN_LEN3  = 255
) (
    input  logic                win_sel,
    input  logic [1:0]          run_sel,
    output logic [LD_GAP_W-1:0] lock_thr,
    output logic [LD_GAP_W-1:0] unlock_thr,
    output logic [LD_GAP_W-1:0] tmo_thr,
    output logic [LD_RUN_W-1:0] run_target
);
    localparam logic [LD_GAP_W-1:0] LO_L = LD_GAP_W'(LO_LOCK);
    localparam logic [LD_GAP_W-1:0] LO_U = LD_GAP_W'(LO_UNLOCK);
    localparam logic [LD_GAP_W-1:0] HI_L = LD_GAP_W'(HI_LOCK);
    localparam logic [LD_GAP_W-1:0] HI_U = LD_GAP_W'(HI_UNLOCK);
    localparam logic [LD_GAP_W-1:0] LO_T = LD_GAP_W'(2 * LO_UNLOCK);
    localparam logic [LD_GAP_W-1:0] HI_T = LD_GAP_W'(2 * HI_UNLOCK);

    always_comb begin
        lock_thr   = win_sel ? HI_L : LO_L;
        unlock_thr = win_sel ? HI_U : LO_U;
        tmo_thr    = win_sel ? HI_T : LO_T;
        unique case (run_sel)
            2'd0:    run_target = LD_RUN_W'(RUN_LEN0);
            2'd1:    run_target = LD_RUN_W'(RUN_LEN1);
            2'd2:    run_target = LD_RUN_W'(RUN_LEN2);
            default: run_target = LD_RUN_W'(RUN_LEN3);
        endcase
    end
endmodule

// File: rtl/lockdet_gap_meter.sv
module lockdet_gap_meter
    import pll_lockdet_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_edge,
    input  logic                fb_edge,
    input  logic                det_off,
    input  logic [LD_GAP_W-1:0] tmo_thr,
    output meas_t               meas
);
    meter_st_t st_d, st_q;
    logic partner, again;

    always_comb begin
        st_d    = st_q;
        meas    = '0;
        partner = st_q.fb_first ? ref_edge : fb_edge;
        again   = st_q.fb_first ? fb_edge : ref_edge;
        if (det_off) begin
            st_d = '0;
        end else if (!st_q.open) begin
            if (ref_edge && fb_edge) begin
                meas.valid = 1'b1;
                meas.gap   = '0;
            end else if (ref_edge || fb_edge) begin
                st_d.open     = 1'b1;
                st_d.fb_first = fb_edge;
                st_d.cnt      = LD_GAP_W'(1);
            end
        end else if (partner) begin
            meas.valid = 1'b1;
            meas.gap   = st_q.cnt;
            st_d       = '0;
        end else if (again) begin
            meas.valid = 1'b1;
            meas.fail  = 1'b1;
            meas.gap   = st_q.cnt;
            st_d.cnt   = LD_GAP_W'(1);
        end else if (st_q.cnt >= tmo_thr) begin
            meas.valid = 1'b1;
            meas.fail  = 1'b1;
            meas.gap   = st_q.cnt;
            st_d       = '0;
        end else begin
            st_d.cnt = st_q.cnt + LD_GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lockdet_run_ctrl.sv
module lockdet_run_ctrl
    import pll_lockdet_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                det_off,
    input  meas_t               meas,
    input  logic [LD_GAP_W-1:0] lock_thr,
    input  logic [LD_GAP_W-1:0] unlock_thr,
    input  logic [LD_RUN_W-1:0] run_target,
    output logic                locked
);
    run_st_t st_d, st_q;
    logic good, bad;
    logic [LD_RUN_W:0] run_next;

    always_comb begin
        st_d     = st_q;
        good     = meas.valid && !meas.fail && (meas.gap < lock_thr);
        bad      = meas.valid && (meas.fail || (meas.gap > unlock_thr));
        run_next = {1'b0, st_q.run} + 1'b1;
        if (det_off) begin
            st_d = '0;
        end else if (!st_q.locked) begin
            if (good) begin
                if (run_next >= {1'b0, run_target}) begin
                    st_d.locked = 1'b1;
                    st_d.run    = '0;
                end else begin
                    st_d.run = run_next[LD_RUN_W-1:0];
                end
            end else if (meas.valid) begin
                st_d.run = '0;
            end
        end else if (bad) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_lockdet_pkg::*;
#(
    parameter int unsigned LO_LOCK   = 2,
    parameter int unsigned LO_UNLOCK = 4,
    parameter int unsigned HI_LOCK   = 4,
    parameter int unsigned HI_UNLOCK = 8,
    parameter int unsigned RUN_LEN0  = 5,
    parameter int unsigned RUN_LEN1  = 16,
    parameter int unsigned RUN_LEN2  = 64,
    parameter int unsigned RUN_LEN3  = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge,
    input  logic       fb_edge,
    input  logic       win_sel,
    input  logic [1:0] run_sel,
    input  logic       det_off,
    output logic       locked
);
    logic [LD_GAP_W-1:0] lock_thr, unlock_thr, tmo_thr;
    logic [LD_RUN_W-1:0] run_target;
    meas_t               meas;

    lockdet_thresh #(
        .LO_LOCK(LO_LOCK), .LO_UNLOCK(LO_UNLOCK),
        .HI_LOCK(HI_LOCK), .HI_UNLOCK(HI_UNLOCK),
        .RUN_LEN0(RUN_LEN0), .RUN_LEN1(RUN_LEN1),
        .RUN_LEN2(RUN_LEN2), .RUN_LEN3(RUN_LEN3)
    ) u_thresh (
        .win_sel(win_sel), .run_sel(run_sel),
        .lock_thr(lock_thr), .unlock_thr(unlock_thr),
        .tmo_thr(tmo_thr), .run_target(run_target)
    );

    lockdet_gap_meter u_meter (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .det_off(det_off), .tmo_thr(tmo_thr), .meas(meas)
    );

    lockdet_run_ctrl u_run (
        .clk(clk), .rst_n(rst_n), .det_off(det_off), .meas(meas),
        .lock_thr(lock_thr), .unlock_thr(unlock_thr),
        .run_target(run_target), .locked(locked)
    );
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker
    import pll_lockdet_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                det_off,
    input logic                locked,
    input meas_t               meas,
    input logic [LD_GAP_W-1:0] unlock_thr
);
    logic over;
    assign over = meas.valid && (meas.fail || (meas.gap > unlock_thr));

    assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        det_off |=> !locked);

    assert_meter_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        det_off |-> !meas.valid);

    assert_rise_after_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(meas.valid && !meas.fail && !det_off));

    assert_fall_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(det_off || over));

    assert_hysteresis_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !det_off && !over) |=> locked);

    assert_gap_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        meas.valid |-> (meas.gap <= (unlock_thr << 1)));
endmodule

bind pll_lock_detect lockdet_checker u_chk (
    .clk(clk), .rst_n(rst_n), .det_off(det_off), .locked(locked),
    .meas(meas), .unlock_thr(unlock_thr)
);

// File: tb/pll_lock_detect_bench.sv
module pll_lock_detect_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_edge = 1'b0, fb_edge = 1'b0, win_sel = 1'b0, det_off = 1'b0;
    logic [1:0] run_sel = 2'd0;
    logic locked;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pll_lock_detect u_pll_lock_detect (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .win_sel(win_sel), .run_sel(run_sel), .det_off(det_off), .locked(locked)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: locked=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // one detector cycle; returns at the negedge where locked reflects it
    task automatic pfd(int gap, bit fb_first);
        @(negedge clk);
        if (gap == 0) begin
            ref_edge = 1'b1; fb_edge = 1'b1;
            @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
        end else begin
            if (fb_first) fb_edge = 1'b1; else ref_edge = 1'b1;
            @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
            repeat (gap - 1) @(negedge clk);
            if (fb_first) ref_edge = 1'b1; else fb_edge = 1'b1;
            @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
        end
    endtask

    task automatic clear_det();
        @(negedge clk); det_off = 1'b1;
        @(negedge clk); det_off = 1'b0;
    endtask

    task automatic run_good(int n);
        for (int i = 0; i < n; i++) pfd(1, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, locked=%0b expected completion", locked);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", locked, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", locked, 1'b0);

        // R2 and R4: run of 5 in low range
        run_good(4);
        check("R2 four good", locked, 1'b0);
        run_good(1);
        check("R2 fifth good", locked, 1'b1);

        // R3 hysteresis low range
        pfd(3, 1'b0); check("R3 gap3 holds", locked, 1'b1);
        pfd(4, 1'b1); check("R3 gap4 holds", locked, 1'b1);
        pfd(5, 1'b0); check("R3 gap5 drops", locked, 1'b0);

        // R5 marginal gap resets the run
        clear_det();
        run_good(3);
        pfd(2, 1'b0); check("R5 gap2 not good", locked, 1'b0);
        run_good(4); check("R5 run restarted", locked, 1'b0);
        run_good(1); check("R5 full new run", locked, 1'b1);

        // R8 feedback first and simultaneous strobes
        clear_det();
        for (int i = 0; i < 5; i++) pfd(1, 1'b1);
        check("R8 fb first", locked, 1'b1);
        clear_det();
        for (int i = 0; i < 5; i++) pfd(0, 1'b0);
        check("R8 same tick", locked, 1'b1);

        // R7 timeout, low range then high range
        @(negedge clk); ref_edge = 1'b1;
        @(negedge clk); ref_edge = 1'b0;
        repeat (12) @(negedge clk);
        check("R7 low timeout", locked, 1'b0);
        win_sel = 1'b1;
        clear_det();
        run_good(5);
        check("R7 high relock", locked, 1'b1);
        @(negedge clk); fb_edge = 1'b1;
        @(negedge clk); fb_edge = 1'b0;
        repeat (12) @(negedge clk);
        check("R7 high not yet", locked, 1'b1);
        repeat (8) @(negedge clk);
        check("R7 high timeout", locked, 1'b0);
        win_sel = 1'b0;

        // R9 disable holds low
        clear_det();
        run_good(5);
        @(negedge clk); det_off = 1'b1;
        @(negedge clk);
        check("R9 disable drops", locked, 1'b0);
        run_good(6);
        check("R9 ignored while off", locked, 1'b0);
        @(negedge clk); det_off = 1'b0;
        run_good(4);
        check("R9 new run needed", locked, 1'b0);
        run_good(1);
        check("R9 relock", locked, 1'b1);

        // R4 every run length
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 5 : (s == 1) ? 16 : (s == 2) ? 64 : 255;
            run_sel = 2'(s);
            clear_det();
            run_good(n - 1);
            check("R4 one short", locked, 1'b0);
            pfd(1, 1'b1);
            check("R4 exact run", locked, 1'b1);
        end
        run_sel = 2'd0;

        // R6 exhaustive gap sweep in both ranges
        for (int w = 0; w < 2; w++) begin
            int lk, ul;
            lk = w ? 4 : 2;
            ul = w ? 8 : 4;
            win_sel = w[0];
            for (int g = 0; g <= 2 * ul; g++) begin
                clear_det();
                for (int i = 0; i < 5; i++) pfd(g, g[0]);
                check("R6 lock threshold", locked, (g < lk) ? 1'b1 : 1'b0);
                clear_det();
                for (int i = 0; i < 5; i++) pfd(0, 1'b0);
                pfd(g, g[0]);
                check("R6 unlock threshold", locked, (g <= ul) ? 1'b1 : 1'b0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule